// File: doc/BRIEF.md
# Dual Reloading Time-Base Timers

This block provides two independent 16-bit up-counting timers that act as shared time bases for an array of capture/compare channels; each channel downstream picks one of the two counts on its own. Each timer owns a 16-bit reload value. When a count enable arrives while the timer sits at its all-ones value, the timer takes the reload value instead of rolling to zero. In that same cycle it raises a one-cycle overflow strobe, which compare logic downstream uses to mark period ends.

Every timer picks its count enable from one of three sources. The first is a power-of-two prescale of the system clock. The second is a pulse stream from an external auxiliary timer that signals its overflow or underflow. The third, on the first timer only, is the rising edges of an external count pin, which lets that timer count outside events. Software control appears as plain ports: a run bit, a source select, a prescale select, a reload value and a write strobe with data for each timer.

Top module: `dual_timebase`

## Requirements
- R1: After a synchronous reset both counts read 0 and both overflow strobes are low.
- R2: A write strobe loads the write data into that timer at the next clock edge and takes priority over counting. While the run bit is clear, the count holds its value whatever the selected source does.
- R3: A count enable at 16'hFFFF loads the reload value into the timer, and the overflow strobe is high for exactly the one cycle in which the reloaded value first appears. Any other count enable adds one.
- R4: Source select 2'b00 counts the prescaled system clock. Prescale select n (0..7) gives exactly one count per 2^(n+3) system clocks.
- R5: Source select 2'b01 gives one count for every system clock in which the auxiliary overflow input is high.
- R6: Source select 2'b10 on the first timer gives one count per rising edge of the external count pin. The pin passes through two synchronising flip-flops first, and a pin held high gives no further counts.
- R7: Source select 2'b10 on the second timer, and 2'b11 on either timer, stops that timer.
- R8: The two timers are independent. Activity on one timer's sources, run bit or write strobe leaves the other's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_a | input | 1 | Run bit, timer A |
| run_b | input | 1 | Run bit, timer B |
| src_a | input | 2 | Count source select, timer A |
| src_b | input | 2 | Count source select, timer B |
| psel_a | input | 3 | Prescale select, timer A |
| psel_b | input | 3 | Prescale select, timer B |
| aux_ovf | input | 1 | Overflow/underflow pulse from the auxiliary timer |
| ext_cnt | input | 1 | Asynchronous external count pin (timer A only) |
| reload_a | input | 16 | Reload value, timer A |
| reload_b | input | 16 | Reload value, timer B |
| wr_a | input | 1 | Write strobe for the timer A count |
| wr_b | input | 1 | Write strobe for the timer B count |
| wdata | input | 16 | Write data for either timer |
| count_a | output | 16 | Current count, timer A |
| count_b | output | 16 | Current count, timer B |
| ovf_a | output | 1 | One-cycle overflow strobe, timer A |
| ovf_b | output | 1 | One-cycle overflow strobe, timer B |

## Verification
The bench drives the all-ones step and expects the reload value with a single strobe cycle. A design that wraps to zero, or that stretches or loses the strobe, shows a wrong count or a wrong strobe value. It measures prescaled counting over whole multiples of the period, so an off-by-one divider gives a wrong delta. It holds the external pin high for a long time, which a level-sensitive design would count many times. It selects the pin source on the second timer, which a design without the restriction would let count. It also checks that writes land while a timer is stopped and that one timer's traffic never moves the other.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int CNT_W   = 16;
  localparam int PSEL_W  = 3;
  localparam int PS_BASE = 3;

  typedef enum logic [1:0] {
    SRC_PRESCALE = 2'b00,
    SRC_AUX      = 2'b01,
    SRC_EXT      = 2'b10,
    SRC_OFF      = 2'b11
  } src_e;
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int PSEL_W  = 3,
  parameter int PS_BASE = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [2**PSEL_W-1:0]   tick_o
);
  localparam int NSEL  = 2**PSEL_W;
  localparam int DIV_W = PS_BASE + NSEL - 1;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // Tap n fires when the low PS_BASE+n bits are all ones: once per 2^(PS_BASE+n) clocks.
  for (genvar n = 0; n < NSEL; n++) begin : g_tap
    assign tick_o[n] = &div_q[PS_BASE+n-1:0];
  end

  a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/tbt_edge_sync.sv
module tbt_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;

  a_r6_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (wr_i) begin
        cnt_q <= wdata_i;
      end else if (en_i) begin
        if (cnt_q == TOP) begin
          cnt_q <= reload_i;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> cnt_q == $past(wdata_i));
  a_r3_reload_on_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> cnt_q == $past(reload_i));
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    (en_i && !wr_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1) && !ovf_q);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !wr_i) |=> $stable(cnt_q) && !ovf_q);
endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
  import tbt_pkg::*;
#(
  parameter int W   = CNT_W,
  parameter int PSW = PSEL_W,
  parameter int PSB = PS_BASE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_a,
  input  logic           run_b,
  input  logic [1:0]     src_a,
  input  logic [1:0]     src_b,
  input  logic [PSW-1:0] psel_a,
  input  logic [PSW-1:0] psel_b,
  input  logic           aux_ovf,
  input  logic           ext_cnt,
  input  logic [W-1:0]   reload_a,
  input  logic [W-1:0]   reload_b,
  input  logic           wr_a,
  input  logic           wr_b,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   count_a,
  output logic [W-1:0]   count_b,
  output logic           ovf_a,
  output logic           ovf_b
);
  localparam int NT   = 2;
  localparam int NSEL = 2**PSW;

  logic [NSEL-1:0] tick;
  logic            ext_rise;

  tbt_prescaler #(.PSEL_W(PSW), .PS_BASE(PSB)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  tbt_edge_sync u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_cnt), .rise_o(ext_rise)
  );

  logic [1:0]     src_v    [NT];
  logic [PSW-1:0] psel_v   [NT];
  logic           run_v    [NT];
  logic           wr_v     [NT];
  logic [W-1:0]   reload_v [NT];
  logic [W-1:0]   cnt_v    [NT];
  logic           ovf_v    [NT];

  assign src_v[0] = src_a;    assign src_v[1] = src_b;
  assign psel_v[0] = psel_a;  assign psel_v[1] = psel_b;
  assign run_v[0] = run_a;    assign run_v[1] = run_b;
  assign wr_v[0] = wr_a;      assign wr_v[1] = wr_b;
  assign reload_v[0] = reload_a; assign reload_v[1] = reload_b;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    localparam bit HAS_PIN = (t == 0);
    logic en;

    always_comb begin
      unique case (src_e'(src_v[t]))
        SRC_PRESCALE: en = tick[psel_v[t]];
        SRC_AUX:      en = aux_ovf;
        SRC_EXT:      en = HAS_PIN ? ext_rise : 1'b0;
        default:      en = 1'b0;
      endcase
      en = en & run_v[t];
    end

    tbt_counter #(.CNT_W(W)) u_cnt (
      .clk(clk), .rst(rst), .en_i(en), .wr_i(wr_v[t]),
      .wdata_i(wdata), .reload_i(reload_v[t]),
      .cnt_o(cnt_v[t]), .ovf_o(ovf_v[t])
    );
  end

  assign count_a = cnt_v[0];
  assign count_b = cnt_v[1];
  assign ovf_a   = ovf_v[0];
  assign ovf_b   = ovf_v[1];

  a_r7_b_pin_stopped: assert property (@(posedge clk) disable iff (rst)
    (src_b == 2'b10 && !wr_b) |=> $stable(count_b) && !ovf_b);
  a_r7_off_stopped: assert property (@(posedge clk) disable iff (rst)
    (src_a == 2'b11 && !wr_a) |=> $stable(count_a) && !ovf_a);
  a_r2_run_clear_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_b && !wr_b) |=> $stable(count_b));
endmodule

// File: tb/tb_dual_timebase.sv
module tb_dual_timebase;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_a = 0, run_b = 0;
  logic [1:0]  src_a = 2'b11, src_b = 2'b11;
  logic [2:0]  psel_a = 0, psel_b = 0;
  logic        aux_ovf = 0, ext_cnt = 0;
  logic [15:0] reload_a = 0, reload_b = 0;
  logic        wr_a = 0, wr_b = 0;
  logic [15:0] wdata = 0;
  logic [15:0] count_a, count_b;
  logic        ovf_a, ovf_b;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_timebase dut (
    .clk(clk), .rst(rst), .run_a(run_a), .run_b(run_b),
    .src_a(src_a), .src_b(src_b), .psel_a(psel_a), .psel_b(psel_b),
    .aux_ovf(aux_ovf), .ext_cnt(ext_cnt), .reload_a(reload_a), .reload_b(reload_b),
    .wr_a(wr_a), .wr_b(wr_b), .wdata(wdata),
    .count_a(count_a), .count_b(count_b), .ovf_a(ovf_a), .ovf_b(ovf_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_a(input logic [15:0] v);
    @(negedge clk); wdata = v; wr_a = 1'b1;
    @(negedge clk); wr_a = 1'b0;
  endtask

  task automatic write_b(input logic [15:0] v);
    @(negedge clk); wdata = v; wr_b = 1'b1;
    @(negedge clk); wr_b = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count_a", count_a, 0);
    check("R1 count_b", count_b, 0);
    check("R1 ovf", {ovf_a, ovf_b}, 0);
  endtask

  task automatic t_write_hold;
    src_a = 2'b01; run_a = 0;
    write_a(16'h0100);
    check("R2 write lands", count_a, 16'h0100);
    aux_ovf = 1; tick(5); aux_ovf = 0;
    check("R2 held while run clear", count_a, 16'h0100);
  endtask

  task automatic t_aux;
    logic [15:0] b0;
    b0 = count_b;
    run_a = 1; src_a = 2'b01;
    aux_ovf = 1; tick(3); aux_ovf = 0; tick(2);
    check("R5 three aux cycles", count_a, 16'h0103);
    aux_ovf = 1; tick(1); aux_ovf = 0; tick(1);
    check("R5 one aux cycle", count_a, 16'h0104);
    check("R8 B untouched by A traffic", count_b, b0);
  endtask

  task automatic t_overflow;
    run_a = 0;
    write_a(16'hFFFE);
    reload_a = 16'h1234; run_a = 1;
    aux_ovf = 1; tick(1); aux_ovf = 0;
    check("R3 step to FFFF", count_a, 16'hFFFF);
    check("R3 no strobe yet", ovf_a, 0);
    aux_ovf = 1; tick(1); aux_ovf = 0;
    check("R3 reload taken", count_a, 16'h1234);
    check("R3 strobe high", ovf_a, 1);
    tick(1);
    check("R3 strobe one cycle", ovf_a, 0);
    check("R3 count after strobe", count_a, 16'h1234);
  endtask

  task automatic t_prescale;
    logic [15:0] a0, b0;
    run_a = 0; src_a = 2'b01;
    write_b(16'h0000);
    src_b = 2'b00; psel_b = 3'd0; run_b = 1;
    b0 = count_b; a0 = count_a;
    tick(64);
    check("R4 div8 over 64", count_b - b0, 16'd8);
    check("R8 A untouched by B", count_a, a0);
    psel_b = 3'd2; tick(32);
    b0 = count_b; tick(256);
    check("R4 div32 over 256", count_b - b0, 16'd8);
    psel_b = 3'd7; tick(1024);
    b0 = count_b; tick(2048);
    check("R4 div1024 over 2048", count_b - b0, 16'd2);
    run_b = 0;
  endtask

  task automatic t_ext;
    logic [15:0] a0;
    src_a = 2'b10; run_a = 1; tick(2);
    a0 = count_a;
    for (int k = 0; k < 3; k++) begin
      ext_cnt = 1; tick(3); ext_cnt = 0; tick(3);
    end
    tick(4);
    check("R6 three edges", count_a - a0, 16'd3);
    a0 = count_a;
    ext_cnt = 1; tick(30);
    check("R6 level counts once", count_a - a0, 16'd1);
    ext_cnt = 0; tick(4);
  endtask

  task automatic t_stopped;
    logic [15:0] a0, b0;
    src_b = 2'b10; run_b = 1; b0 = count_b;
    for (int k = 0; k < 4; k++) begin
      ext_cnt = 1; tick(3); ext_cnt = 0; tick(3);
    end
    tick(4);
    check("R7 B pin source stopped", count_b, b0);
    src_a = 2'b11; a0 = count_a;
    aux_ovf = 1; tick(40); aux_ovf = 0;
    check("R7 A off source stopped", count_a, a0);
    run_b = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_write_hold();
    t_aux();
    t_overflow();
    t_prescale();
    t_ext();
    t_stopped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule